// File: doc/BRIEF.md
# Segment Address Translator with Access Protection

This block turns a segment-relative memory reference into a 32-bit linear address and decides, in the same pass, whether the reference may proceed. A request carries an access kind (read, write or instruction fetch), a stack flag, an optional segment override, a 32-bit offset and the current privilege level. The block picks one of eight segment registers: a default chosen from the access kind, or the override. It then reads that register's cached descriptor fields (base, limit, descriptor privilege, type) and the requested privilege carried by its selector.

The linear address is the chosen base plus the offset, modulo 2^32. Three checks run in parallel on the request. The privilege check compares the descriptor privilege with both the requested and the current level. The limit check compares the offset with the segment limit. The permission check compares the access kind with the segment type. When more than one check fails, a priority order picks a single fault code. Everything is captured in one register stage, so the result appears one cycle after the request. Each segment is checked only against its own fields; overlap between segments is legal and is never examined. Loading descriptors and paging belong to other blocks.

Top module: `seg_xlate`

## Requirements
- R1: For a valid request, `out_lin` equals the selected segment's base plus `in_offset`, wrapping modulo 2^32.
- R2: Without an override, segment IDs are ES=0, CS=1, SS=2, DS=3, FS=4 and 5 to 7 for further registers. A fetch (`in_kind` 2'b10 or 2'b11) uses CS whatever `in_stack` says. A read (2'b00) or write (2'b01) uses SS when `in_stack` is 1 and DS otherwise. The chosen ID appears on `out_seg`.
- R3: When `in_ovr_en` is 1, the segment given by `in_ovr_seg` (any of 0 to 7) replaces the default.
- R4: A privilege fault (`out_fault` = 2'b01) is reported when the segment's descriptor privilege is greater than its selector's requested privilege, or greater than `in_cpl`. It is not reported when the descriptor privilege is at most both levels.
- R5: An offset strictly greater than the segment limit raises a limit fault (2'b10). An offset equal to the limit is accepted.
- R6: Segment type codes are 00 read-only data, 01 read-write data, 10 execute-only code and 11 execute-readable code. Reads are allowed on types 00, 01 and 11. Writes are allowed only on type 01. Fetches are allowed only on types 10 and 11. Any other combination raises a permission fault (2'b11).
- R7: When several faults apply, the reported code is privilege first, then limit, then permission.
- R8: `out_grant` is 1 only while `out_valid` is 1 and `out_fault` is 2'b00. `out_grant` is 0 for every faulted result.
- R9: A request presented with `in_valid` at a clock edge produces its result with `out_valid` = 1 after that edge. Back-to-back requests yield back-to-back results. In a cycle without a request, `out_valid` and `out_grant` drop to 0 while `out_lin`, `out_seg` and `out_fault` keep their last values.
- R10: While reset is held, `out_valid`, `out_grant`, `out_fault` and `out_lin` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request present this cycle |
| in_kind | input | 2 | 00 read, 01 write, 1x fetch |
| in_stack | input | 1 | Data reference goes to the stack by default |
| in_ovr_en | input | 1 | Use `in_ovr_seg` instead of the default segment |
| in_ovr_seg | input | 3 | Override segment ID |
| in_offset | input | 32 | Offset within the segment |
| in_cpl | input | 2 | Current privilege level |
| seg_base | input | 256 | Eight 32-bit cached bases, ID n at bits [32n+31:32n] |
| seg_limit | input | 256 | Eight 32-bit cached limits, same packing |
| seg_dpl | input | 16 | Eight 2-bit descriptor privilege levels |
| seg_rpl | input | 16 | Eight 2-bit requested privilege levels from the selectors |
| seg_type | input | 16 | Eight 2-bit segment type codes |
| out_valid | output | 1 | Result valid |
| out_seg | output | 3 | Segment ID used |
| out_lin | output | 32 | Linear address |
| out_grant | output | 1 | Access allowed |
| out_fault | output | 2 | 00 none, 01 privilege, 10 limit, 11 permission |

## Verification
The hardest case to reach is one where all three faults apply at once, because it needs a single segment whose privilege, limit and type all disagree with the same request. The stimulus edits the cached fields of DS between requests to build this overlap. It then removes the privilege fault alone and checks that the limit fault takes over. The limit boundary is probed at offsets equal to the limit and one above it, and address wrap is reached with a base near the top of the address space.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEG_ID_W = 3;
  localparam int NUM_SEG  = 1 << SEG_ID_W;

  localparam logic [SEG_ID_W-1:0] SEG_ES = 3'd0;
  localparam logic [SEG_ID_W-1:0] SEG_CS = 3'd1;
  localparam logic [SEG_ID_W-1:0] SEG_SS = 3'd2;
  localparam logic [SEG_ID_W-1:0] SEG_DS = 3'd3;
  localparam logic [SEG_ID_W-1:0] SEG_FS = 3'd4;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_PRIV  = 2'b01,
    FLT_LIMIT = 2'b10,
    FLT_PERM  = 2'b11
  } fault_e;

  typedef enum logic [1:0] {
    DT_RO = 2'b00,
    DT_RW = 2'b01,
    DT_XO = 2'b10,
    DT_XR = 2'b11
  } dtype_e;

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2
) (
  input  logic [1:0]              kind,
  input  logic                    stack,
  input  logic                    ovr_en,
  input  logic [SEG_ID_W-1:0]     ovr_seg,
  input  logic [NUM_SEG*ADDR_W-1:0] seg_base,
  input  logic [NUM_SEG*ADDR_W-1:0] seg_limit,
  input  logic [NUM_SEG*PL_W-1:0] seg_dpl,
  input  logic [NUM_SEG*PL_W-1:0] seg_rpl,
  input  logic [NUM_SEG*2-1:0]    seg_type,
  output logic [SEG_ID_W-1:0]     sel_id,
  output logic [ADDR_W-1:0]       sel_base,
  output logic [ADDR_W-1:0]       sel_limit,
  output logic [PL_W-1:0]         sel_dpl,
  output logic [PL_W-1:0]         sel_rpl,
  output logic [1:0]              sel_type
);

  logic [ADDR_W-1:0] base_a  [NUM_SEG];
  logic [ADDR_W-1:0] limit_a [NUM_SEG];
  logic [PL_W-1:0]   dpl_a   [NUM_SEG];
  logic [PL_W-1:0]   rpl_a   [NUM_SEG];
  logic [1:0]        type_a  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_unpack
    assign base_a[g]  = seg_base[g*ADDR_W +: ADDR_W];
    assign limit_a[g] = seg_limit[g*ADDR_W +: ADDR_W];
    assign dpl_a[g]   = seg_dpl[g*PL_W +: PL_W];
    assign rpl_a[g]   = seg_rpl[g*PL_W +: PL_W];
    assign type_a[g]  = seg_type[g*2 +: 2];
  end

  // default selection: fetch beats stack flag; override beats both
  always_comb begin
    if (ovr_en)       sel_id = ovr_seg;
    else if (kind[1]) sel_id = SEG_CS;
    else if (stack)   sel_id = SEG_SS;
    else              sel_id = SEG_DS;
  end

  assign sel_base  = base_a[sel_id];
  assign sel_limit = limit_a[sel_id];
  assign sel_dpl   = dpl_a[sel_id];
  assign sel_rpl   = rpl_a[sel_id];
  assign sel_type  = type_a[sel_id];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] offset,
  input  logic [PL_W-1:0]   cpl,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic [PL_W-1:0]   dpl,
  input  logic [PL_W-1:0]   rpl,
  input  logic [1:0]        dtype,
  output logic [ADDR_W-1:0] lin,
  output fault_e            fault
);

  logic priv_bad;
  logic lim_bad;
  logic perm_ok;

  assign lin      = base + offset;
  assign priv_bad = (dpl > rpl) || (dpl > cpl);
  assign lim_bad  = offset > limit;

  always_comb begin
    perm_ok = 1'b0;
    if (kind[1]) begin
      perm_ok = (dtype == DT_XO) || (dtype == DT_XR);
    end else if (kind == KIND_WRITE) begin
      perm_ok = (dtype == DT_RW);
    end else begin
      perm_ok = (dtype != DT_XO);
    end
  end

  always_comb begin
    if (priv_bad)      fault = FLT_PRIV;
    else if (lim_bad)  fault = FLT_LIMIT;
    else if (!perm_ok) fault = FLT_PERM;
    else               fault = FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PL_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                in_kind,
  input  logic                      in_stack,
  input  logic                      in_ovr_en,
  input  logic [2:0]                in_ovr_seg,
  input  logic [ADDR_W-1:0]         in_offset,
  input  logic [PL_W-1:0]           in_cpl,
  input  logic [8*ADDR_W-1:0]       seg_base,
  input  logic [8*ADDR_W-1:0]       seg_limit,
  input  logic [8*PL_W-1:0]         seg_dpl,
  input  logic [8*PL_W-1:0]         seg_rpl,
  input  logic [15:0]               seg_type,
  output logic                      out_valid,
  output logic [2:0]                out_seg,
  output logic [ADDR_W-1:0]         out_lin,
  output logic                      out_grant,
  output logic [1:0]                out_fault
);

  logic                rst_sync_n;
  logic [SEG_ID_W-1:0] pick_id;
  logic [ADDR_W-1:0]   pick_base;
  logic [ADDR_W-1:0]   pick_limit;
  logic [PL_W-1:0]     pick_dpl;
  logic [PL_W-1:0]     pick_rpl;
  logic [1:0]          pick_type;
  logic [ADDR_W-1:0]   chk_lin;
  fault_e              chk_fault;

  logic                valid_q, valid_d;
  logic                grant_q, grant_d;
  logic [SEG_ID_W-1:0] seg_q,   seg_d;
  logic [ADDR_W-1:0]   lin_q,   lin_d;
  fault_e              fault_q, fault_d;

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_pick #(.ADDR_W(ADDR_W), .PL_W(PL_W)) u_pick (
    .kind      (in_kind),
    .stack     (in_stack),
    .ovr_en    (in_ovr_en),
    .ovr_seg   (in_ovr_seg),
    .seg_base  (seg_base),
    .seg_limit (seg_limit),
    .seg_dpl   (seg_dpl),
    .seg_rpl   (seg_rpl),
    .seg_type  (seg_type),
    .sel_id    (pick_id),
    .sel_base  (pick_base),
    .sel_limit (pick_limit),
    .sel_dpl   (pick_dpl),
    .sel_rpl   (pick_rpl),
    .sel_type  (pick_type)
  );

  seg_check #(.ADDR_W(ADDR_W), .PL_W(PL_W)) u_check (
    .kind   (in_kind),
    .offset (in_offset),
    .cpl    (in_cpl),
    .base   (pick_base),
    .limit  (pick_limit),
    .dpl    (pick_dpl),
    .rpl    (pick_rpl),
    .dtype  (pick_type),
    .lin    (chk_lin),
    .fault  (chk_fault)
  );

  // next state: capture on a request, otherwise hold result fields
  always_comb begin
    valid_d = in_valid;
    seg_d   = seg_q;
    lin_d   = lin_q;
    fault_d = fault_q;
    grant_d = 1'b0;
    if (in_valid) begin
      seg_d   = pick_id;
      lin_d   = chk_lin;
      fault_d = chk_fault;
      grant_d = (chk_fault == FLT_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      grant_q <= 1'b0;
      seg_q   <= '0;
      lin_q   <= '0;
      fault_q <= FLT_NONE;
    end else begin
      valid_q <= valid_d;
      grant_q <= grant_d;
      seg_q   <= seg_d;
      lin_q   <= lin_d;
      fault_q <= fault_d;
    end
  end

  assign out_valid = valid_q;
  assign out_grant = grant_q;
  assign out_seg   = seg_q;
  assign out_lin   = lin_q;
  assign out_fault = fault_q;

  a_r1_lin_sum: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_lin == $past(pick_base + in_offset));

  a_r4_priv_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && ((pick_dpl > pick_rpl) || (pick_dpl > in_cpl)))
      |=> out_fault == FLT_PRIV);

  a_r5_limit_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (pick_dpl <= pick_rpl) && (pick_dpl <= in_cpl) && (in_offset > pick_limit))
      |=> out_fault == FLT_LIMIT);

  a_r8_grant_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_grant |-> out_valid && (out_fault == FLT_NONE));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid && !out_grant && $stable(out_lin) && $stable(out_fault));

endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_kind;
  logic        in_stack;
  logic        in_ovr_en;
  logic [2:0]  in_ovr_seg;
  logic [31:0] in_offset;
  logic [1:0]  in_cpl;
  logic [255:0] seg_base;
  logic [255:0] seg_limit;
  logic [15:0] seg_dpl;
  logic [15:0] seg_rpl;
  logic [15:0] seg_type;
  logic        out_valid;
  logic [2:0]  out_seg;
  logic [31:0] out_lin;
  logic        out_grant;
  logic [1:0]  out_fault;

  logic [31:0] base_a  [8];
  logic [31:0] limit_a [8];
  logic [1:0]  dpl_a   [8];
  logic [1:0]  rpl_a   [8];
  logic [1:0]  type_a  [8];

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  for (genvar g = 0; g < 8; g++) begin : g_pack
    assign seg_base[g*32 +: 32]  = base_a[g];
    assign seg_limit[g*32 +: 32] = limit_a[g];
    assign seg_dpl[g*2 +: 2]     = dpl_a[g];
    assign seg_rpl[g*2 +: 2]     = rpl_a[g];
    assign seg_type[g*2 +: 2]    = type_a[g];
  end

  seg_xlate dut_i (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_kind (in_kind),
    .in_stack (in_stack), .in_ovr_en (in_ovr_en), .in_ovr_seg (in_ovr_seg),
    .in_offset (in_offset), .in_cpl (in_cpl), .seg_base (seg_base),
    .seg_limit (seg_limit), .seg_dpl (seg_dpl), .seg_rpl (seg_rpl),
    .seg_type (seg_type), .out_valid (out_valid), .out_seg (out_seg),
    .out_lin (out_lin), .out_grant (out_grant), .out_fault (out_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_out(string tag, logic ev, logic [2:0] es, logic [31:0] el,
                            logic eg, logic [1:0] ef);
    n_checks++;
    if (out_valid !== ev || out_seg !== es || out_lin !== el ||
        out_grant !== eg || out_fault !== ef) begin
      n_errors++;
      $display("FAIL %s: got v=%0b seg=%0d lin=%h g=%0b f=%b, expected v=%0b seg=%0d lin=%h g=%0b f=%b",
               tag, out_valid, out_seg, out_lin, out_grant, out_fault,
               ev, es, el, eg, ef);
    end
  endtask

  task automatic set_req(logic [1:0] kind, logic stk, logic oen, logic [2:0] oseg,
                         logic [31:0] off, logic [1:0] cpl);
    in_kind = kind; in_stack = stk; in_ovr_en = oen; in_ovr_seg = oseg;
    in_offset = off; in_cpl = cpl; in_valid = 1'b1;
  endtask

  task automatic issue(logic [1:0] kind, logic stk, logic oen, logic [2:0] oseg,
                       logic [31:0] off, logic [1:0] cpl);
    @(negedge clk);
    set_req(kind, stk, oen, oseg, off, cpl);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic restore_desc();
    for (int i = 0; i < 8; i++) begin
      base_a[i]  = 32'h1000_0000 * i + 32'h40;
      limit_a[i] = 32'h0000_FFFF;
      dpl_a[i]   = 2'd0;
      rpl_a[i]   = 2'd3;
      type_a[i]  = (i == 1) ? 2'b11 : 2'b01;
    end
  endtask

  task automatic t_reset();
    expect_out("R10 reset state", 1'b0, 3'd0, 32'h0, 1'b0, 2'b00);
  endtask

  task automatic t_defaults();
    issue(2'b10, 1'b0, 1'b0, 3'd0, 32'h1234, 2'd0);
    expect_out("R2 fetch defaults to CS", 1'b1, 3'd1, 32'h1000_1274, 1'b1, 2'b00);
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h10, 2'd0);
    expect_out("R2 read defaults to DS", 1'b1, 3'd3, 32'h3000_0050, 1'b1, 2'b00);
    issue(2'b01, 1'b1, 1'b0, 3'd0, 32'h200, 2'd0);
    expect_out("R2 stack write defaults to SS", 1'b1, 3'd2, 32'h2000_0240, 1'b1, 2'b00);
    issue(2'b11, 1'b1, 1'b0, 3'd0, 32'h8, 2'd0);
    expect_out("R2 fetch ignores stack flag", 1'b1, 3'd1, 32'h1000_0048, 1'b1, 2'b00);
  endtask

  task automatic t_override();
    issue(2'b00, 1'b0, 1'b1, 3'd0, 32'h4, 2'd0);
    expect_out("R3 override ES", 1'b1, 3'd0, 32'h0000_0044, 1'b1, 2'b00);
    issue(2'b01, 1'b1, 1'b1, 3'd4, 32'h4, 2'd0);
    expect_out("R3 override FS beats stack", 1'b1, 3'd4, 32'h4000_0044, 1'b1, 2'b00);
    issue(2'b00, 1'b0, 1'b1, 3'd7, 32'h4, 2'd0);
    expect_out("R3 override ID 7", 1'b1, 3'd7, 32'h7000_0044, 1'b1, 2'b00);
  endtask

  task automatic t_wrap();
    base_a[3] = 32'hFFFF_FFF0; limit_a[3] = 32'hFFFF_FFFF;
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h20, 2'd0);
    expect_out("R1 address wraps", 1'b1, 3'd3, 32'h0000_0010, 1'b1, 2'b00);
    restore_desc();
  endtask

  task automatic t_priv();
    dpl_a[3] = 2'd2;
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0, 2'd1);
    expect_out("R4 dpl above cpl", 1'b1, 3'd3, 32'h3000_0040, 1'b0, 2'b01);
    rpl_a[3] = 2'd1;
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0, 2'd2);
    expect_out("R4 dpl above rpl", 1'b1, 3'd3, 32'h3000_0040, 1'b0, 2'b01);
    rpl_a[3] = 2'd2;
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0, 2'd2);
    expect_out("R4 dpl equal both levels", 1'b1, 3'd3, 32'h3000_0040, 1'b1, 2'b00);
    restore_desc();
  endtask

  task automatic t_limit();
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0000_FFFF, 2'd0);
    expect_out("R5 offset at limit", 1'b1, 3'd3, 32'h3001_003F, 1'b1, 2'b00);
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0001_0000, 2'd0);
    expect_out("R5 offset past limit", 1'b1, 3'd3, 32'h3001_0040, 1'b0, 2'b10);
  endtask

  task automatic t_perm();
    type_a[3] = 2'b00;
    issue(2'b01, 1'b0, 1'b0, 3'd0, 32'h0, 2'd0);
    expect_out("R6 write to read-only", 1'b1, 3'd3, 32'h3000_0040, 1'b0, 2'b11);
    issue(2'b00, 1'b0, 1'b0, 3'd0, 32'h0, 2'd0);
    expect_out("R6 read of read-only", 1'b1, 3'd3, 32'h3000_0040, 1'b1, 2'b00);
    type_a[3] = 2'b01;
    issue(2'b10, 1'b0, 1'b1, 3'd3, 32'h0, 2'd0);
    expect_out("R6 fetch from data", 1'b1, 3'd3, 32'h3000_0040, 1'b0, 2'b11);
    type_a[1] = 2'b10;
    issue(2'b00, 1'b0, 1'b1, 3'd1, 32'h0, 2'd0);
    expect_out("R6 read of execute-only", 1'b1, 3'd1, 32'h1000_0040, 1'b0, 2'b11);
    issue(2'b10, 1'b0, 1'b0, 3'd0, 32'h0, 2'd0);
    expect_out("R6 fetch of execute-only", 1'b1, 3'd1, 32'h1000_0040, 1'b1, 2'b00);
    type_a[1] = 2'b11;
    issue(2'b00, 1'b0, 1'b1, 3'd1, 32'h0, 2'd0);
    expect_out("R6 read of execute-readable", 1'b1, 3'd1, 32'h1000_0040, 1'b1, 2'b00);
    issue(2'b01, 1'b0, 1'b1, 3'd1, 32'h0, 2'd0);
    expect_out("R6 write to code", 1'b1, 3'd1, 32'h1000_0040, 1'b0, 2'b11);
    restore_desc();
  endtask

  task automatic t_priority();
    dpl_a[3] = 2'd3; type_a[3] = 2'b00;
    issue(2'b01, 1'b0, 1'b0, 3'd0, 32'h0002_0000, 2'd0);
    expect_out("R7 privilege wins over all", 1'b1, 3'd3, 32'h3002_0040, 1'b0, 2'b01);
    dpl_a[3] = 2'd0;
    issue(2'b01, 1'b0, 1'b0, 3'd0, 32'h0002_0000, 2'd0);
    expect_out("R7 limit wins over permission", 1'b1, 3'd3, 32'h3002_0040, 1'b0, 2'b10);
    restore_desc();
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    set_req(2'b00, 1'b0, 1'b0, 3'd0, 32'h1, 2'd0);
    @(negedge clk);
    expect_out("R9 first of pair", 1'b1, 3'd3, 32'h3000_0041, 1'b1, 2'b00);
    set_req(2'b00, 1'b1, 1'b0, 3'd0, 32'h2, 2'd0);
    @(negedge clk);
    expect_out("R9 second of pair", 1'b1, 3'd2, 32'h2000_0042, 1'b1, 2'b00);
    in_valid = 1'b0;
    in_offset = 32'hDEAD_0000;
    @(negedge clk);
    expect_out("R9 R8 idle holds result", 1'b0, 3'd2, 32'h2000_0042, 1'b0, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_kind = 2'b00; in_stack = 1'b0; in_ovr_en = 1'b0;
    in_ovr_seg = 3'd0; in_offset = 32'h0; in_cpl = 2'd0;
    restore_desc();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_defaults();
    t_override();
    t_wrap();
    t_priv();
    t_limit();
    t_perm();
    t_priority();
    t_pipeline();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule